// File: doc/BRIEF.md
# Serial Debug Register Access Port

This block lets an external debugger reach a small bank of debug registers through one test-access data register. Each scan moves a 38-bit frame through a shift register clocked by the test clock: bits 31:0 carry data, bits 36:32 carry a register address, and bit 37 is the direction flag. The frame enters serially from `tdi`, least significant bit first, while the previously captured frame leaves on `tdo`. A test-access controller outside this block supplies one-cycle capture, shift and update strobes.

A write frame (flag 1) stores its data into the addressed register when the update strobe arrives. Reads take two scans. At update, a read frame (flag 0) only latches its address. On the next capture, the selected register's value is loaded into the data field and shifted out while the following frame comes in. The debugger ends a burst of reads with a harmless address, and comms control is the usual choice. The register bank holds these registers:

- debug control at address 0, 6 bits
- core status at address 1, 5 bits, read-only and driven by the core
- vector catch at address 2, 8 bits, present only when a parameter enables it
- comms control at address 4, 6 bits
- comms data at address 5, 32 bits
- two watchpoint groups at addresses 8 to 13 and 16 to 21. Each group holds an address value, an address mask, a data value and a data mask, all 32 bits wide, followed by a 9-bit control value and an 8-bit control mask.

Bit 4 of debug control drives the monitor-mode enable output. When that bit is 0, the core uses halting debug.

A small phase state machine tracks the scan. The states are PH_IDLE, PH_CAPTURED and PH_SHIFTING. The transitions are:

- any state to PH_CAPTURED on capture
- PH_CAPTURED or PH_SHIFTING to PH_SHIFTING on shift
- PH_CAPTURED or PH_SHIFTING to PH_IDLE on update, which commits the frame
- PH_IDLE stays in PH_IDLE on shift or update, and nothing is committed

Top module: `dbg_scan_port`

## Requirements
- R1: While `trst_n` is low, every stored register clears to zero, the monitor-mode output is 0 and the latched read address returns to 4 (comms control). The first scan after reset therefore returns data 0.
- R2: The frame shifts LSB first from `tdi` toward `tdo`. Frame bits 31:0 hold data, bits 36:32 hold the address and bit 37 holds the direction flag.
- R3: At a committing update with flag 1, the data field is stored into the register at the frame's address.
- R4: At a committing update with flag 0, the frame's address is latched. The next capture loads that register's value into data bits 31:0.
- R5: Register bits above a register's implemented width read as zero and ignore writes. A capture also clears frame bits 37:32.
- R6: Addresses with no register (3, 6, 7, 14, 15, 22 to 31) read as zero, and writes to them have no effect.
- R7: Address 1 returns `core_status` zero-extended. Writes to address 1 have no effect.
- R8: With `HAS_VCATCH` set, address 2 stores 8 bits. With it clear, address 2 reads as zero.
- R9: `monitor_mode` equals bit 4 of the debug control register at address 0.
- R10: An update that arrives in PH_IDLE, with no capture since the last update, commits nothing.
- R11: A write frame does not change the latched read address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial data in |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| core_status | input | 5 | Status bits from the core, readable at address 1 |
| tdo | output | 1 | Serial data out, equal to frame bit 0 |
| monitor_mode | output | 1 | Monitor-mode enable, bit 4 of debug control |

## Verification
The assertions check on every cycle that:
- a shift moves frame bit 1 onto `tdo`
- a capture clears the frame's top six bits
- a read commit latches the frame's address, and a write commit leaves that address alone
- a debug-control write reaches `monitor_mode`
- an update in PH_IDLE changes neither the read address nor `monitor_mode`

Only the bench scenarios show the rest:
- the width masking of each register
- the zero reads of unmapped addresses
- the read-only status register
- the two-scan read pipeline as the debugger sees it, including what a stray update leaves in the bank
- the reset state seen through a fresh scan

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 5;
    localparam int FRAME_W  = DATA_W + ADDR_W + 1;
    localparam int NREGS    = 1 << ADDR_W;
    localparam int DIR_BIT  = FRAME_W - 1;
    localparam int STAT_W   = 5;

    localparam int A_DBGCTL = 0;
    localparam int A_STATUS = 1;
    localparam int A_VCATCH = 2;
    localparam int A_CCTRL  = 4;
    localparam int A_CDATA  = 5;
    localparam int MON_BIT  = 4;

    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_CAPTURED = 2'd1,
        PH_SHIFTING = 2'd2
    } scan_phase_e;

    // Implemented bits of each address; zero means no storage.
    function automatic logic [DATA_W-1:0] field_mask(input int a, input bit vcatch);
        logic [DATA_W-1:0] m;
        m = '0;
        case (a)
            A_DBGCTL:             m = 32'h0000_003F;
            A_STATUS:             m = 32'h0000_001F;
            A_VCATCH:             m = vcatch ? 32'h0000_00FF : 32'h0;
            A_CCTRL:              m = 32'h0000_003F;
            A_CDATA:              m = 32'hFFFF_FFFF;
            8, 9, 10, 11:         m = 32'hFFFF_FFFF;
            16, 17, 18, 19:       m = 32'hFFFF_FFFF;
            12, 20:               m = 32'h0000_01FF;
            13, 21:               m = 32'h0000_00FF;
            default:              m = '0;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/dbg_scan_fsm.sv
module dbg_scan_fsm
    import dbg_scan_pkg::*;
(
    input  logic tck,
    input  logic trst_n,
    input  logic capture_en,
    input  logic shift_en,
    input  logic update_en,
    output logic commit
);
    scan_phase_e phase_q, phase_d;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) phase_q <= PH_IDLE;
        else         phase_q <= phase_d;
    end

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (capture_en) phase_d = PH_CAPTURED;
            end
            PH_CAPTURED, PH_SHIFTING: begin
                if (capture_en)     phase_d = PH_CAPTURED;
                else if (shift_en)  phase_d = PH_SHIFTING;
                else if (update_en) phase_d = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_comb begin
        commit = 1'b0;
        unique case (phase_q)
            PH_IDLE:                  commit = 1'b0;
            PH_CAPTURED, PH_SHIFTING: commit = update_en && !capture_en && !shift_en;
            default:                  commit = 1'b0;
        endcase
    end
endmodule

// File: rtl/dbg_scan_shifter.sv
module dbg_scan_shifter
    import dbg_scan_pkg::*;
(
    input  logic               tck,
    input  logic               trst_n,
    input  logic               capture_en,
    input  logic               shift_en,
    input  logic               tdi,
    input  logic [DATA_W-1:0]  cap_data,
    output logic [FRAME_W-1:0] frame,
    output logic               tdo
);
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            frame <= '0;
        end else if (capture_en) begin
            frame <= {{(FRAME_W-DATA_W){1'b0}}, cap_data};
        end else if (shift_en) begin
            frame <= {tdi, frame[FRAME_W-1:1]};
        end
    end

    assign tdo = frame[0];
endmodule

// File: rtl/dbg_scan_regfile.sv
module dbg_scan_regfile
    import dbg_scan_pkg::*;
#(
    parameter bit HAS_VCATCH = 1'b1
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              commit,
    input  logic              dir_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STAT_W-1:0] core_status,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rdata,
    output logic              monitor_mode
);
    logic [DATA_W-1:0] q [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        localparam logic [DATA_W-1:0] MASK = field_mask(i, HAS_VCATCH);
        if (i == A_STATUS) begin : g_stat
            assign q[i] = {{(DATA_W-STAT_W){1'b0}}, core_status} & MASK;
        end else if (MASK == '0) begin : g_none
            assign q[i] = '0;
        end else begin : g_store
            logic [DATA_W-1:0] val;
            always_ff @(posedge tck or negedge trst_n) begin
                if (!trst_n)
                    val <= '0;
                else if (commit && dir_wr && addr == ADDR_W'(i))
                    val <= wdata & MASK;
            end
            assign q[i] = val;
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                rd_addr <= ADDR_W'(A_CCTRL);
        else if (commit && !dir_wr) rd_addr <= addr;
    end

    assign rdata        = q[rd_addr];
    assign monitor_mode = q[A_DBGCTL][MON_BIT];
endmodule

// File: rtl/dbg_scan_port.sv
module dbg_scan_port
    import dbg_scan_pkg::*;
#(
    parameter bit HAS_VCATCH = 1'b1
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tdi,
    input  logic              capture_en,
    input  logic              shift_en,
    input  logic              update_en,
    input  logic [STAT_W-1:0] core_status,
    output logic              tdo,
    output logic              monitor_mode
);
    logic [FRAME_W-1:0] frame;
    logic [DATA_W-1:0]  rdata;
    logic [ADDR_W-1:0]  rd_addr;
    logic               commit;

    dbg_scan_fsm u_fsm (
        .tck        (tck),
        .trst_n     (trst_n),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .update_en  (update_en),
        .commit     (commit)
    );

    dbg_scan_shifter u_shift (
        .tck        (tck),
        .trst_n     (trst_n),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .tdi        (tdi),
        .cap_data   (rdata),
        .frame      (frame),
        .tdo        (tdo)
    );

    dbg_scan_regfile #(.HAS_VCATCH(HAS_VCATCH)) u_regs (
        .tck          (tck),
        .trst_n       (trst_n),
        .commit       (commit),
        .dir_wr       (frame[DIR_BIT]),
        .addr         (frame[DATA_W +: ADDR_W]),
        .wdata        (frame[DATA_W-1:0]),
        .core_status  (core_status),
        .rd_addr      (rd_addr),
        .rdata        (rdata),
        .monitor_mode (monitor_mode)
    );
endmodule

// File: rtl/dbg_scan_port_chk.sv
module dbg_scan_port_chk
    import dbg_scan_pkg::*;
(
    input logic               tck,
    input logic               trst_n,
    input logic               capture_en,
    input logic               shift_en,
    input logic               update_en,
    input logic               tdo,
    input logic               monitor_mode,
    input logic [FRAME_W-1:0] frame,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic               commit
);
    assert_shift_lsb_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (shift_en && !capture_en) |=> tdo == $past(frame[1]));

    assert_capture_top_clear_R5: assert property (@(posedge tck) disable iff (!trst_n)
        capture_en |=> frame[FRAME_W-1:DATA_W] == '0);

    assert_read_latch_R4: assert property (@(posedge tck) disable iff (!trst_n)
        (commit && !frame[DIR_BIT]) |=> rd_addr == $past(frame[DATA_W +: ADDR_W]));

    assert_write_keeps_addr_R11: assert property (@(posedge tck) disable iff (!trst_n)
        (commit && frame[DIR_BIT]) |=> $stable(rd_addr));

    assert_monitor_bit_R9: assert property (@(posedge tck) disable iff (!trst_n)
        (commit && frame[DIR_BIT] && frame[DATA_W +: ADDR_W] == ADDR_W'(A_DBGCTL))
        |=> monitor_mode == $past(frame[MON_BIT]));

    assert_stray_update_R10: assert property (@(posedge tck) disable iff (!trst_n)
        (update_en && !capture_en && !shift_en && !commit)
        |=> ($stable(rd_addr) && $stable(monitor_mode)));
endmodule

bind dbg_scan_port dbg_scan_port_chk u_chk (
    .tck          (tck),
    .trst_n       (trst_n),
    .capture_en   (capture_en),
    .shift_en     (shift_en),
    .update_en    (update_en),
    .tdo          (tdo),
    .monitor_mode (monitor_mode),
    .frame        (frame),
    .rd_addr      (rd_addr),
    .commit       (commit)
);

// File: tb/dbg_scan_port_tb.sv
module dbg_scan_port_tb;
    logic       tck = 1'b0;
    logic       trst_n = 1'b0;
    logic       tdi = 1'b0;
    logic       capture_en = 1'b0;
    logic       shift_en = 1'b0;
    logic       update_en = 1'b0;
    logic [4:0] core_status = 5'h0;
    logic       tdo;
    logic       monitor_mode;
    int checks = 0;
    int errors = 0;

    always #4 tck = ~tck;

    dbg_scan_port u_dut (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .capture_en(capture_en),
        .shift_en(shift_en), .update_en(update_en), .core_status(core_status),
        .tdo(tdo), .monitor_mode(monitor_mode)
    );

    task automatic check(input bit ok, input string req, input logic [37:0] act, input logic [37:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic scan(input logic [37:0] f, output logic [37:0] got);
        @(negedge tck); capture_en = 1'b1;
        @(negedge tck); capture_en = 1'b0;
        for (int i = 0; i < 38; i++) begin
            got[i] = tdo; tdi = f[i]; shift_en = 1'b1;
            @(negedge tck);
        end
        shift_en = 1'b0; update_en = 1'b1;
        @(negedge tck); update_en = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        logic [37:0] g;
        scan({1'b1, a, d}, g);
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        logic [37:0] g;
        scan({1'b0, a, 32'h0}, g);
        scan({1'b0, 5'd4, 32'h0}, g);
        d = g[31:0];
    endtask

    task automatic t_reset_state;
        logic [37:0] g;
        scan({1'b0, 5'd4, 32'h0}, g);
        check(g == 38'h0, "R1 first capture after reset", g, 38'h0);
        check(monitor_mode == 1'b0, "R1 monitor after reset", 38'(monitor_mode), 38'h0);
    endtask

    task automatic t_write_read;
        logic [31:0] d;
        wr(5'd8, 32'hDEAD_BEEF); rd(5'd8, d);
        check(d == 32'hDEAD_BEEF, "R3 R2 wp0 address value", 38'(d), 38'hDEAD_BEEF);
        wr(5'd17, 32'h1234_5678); rd(5'd17, d);
        check(d == 32'h1234_5678, "R3 wp1 address mask", 38'(d), 38'h1234_5678);
        wr(5'd5, 32'hA5A5_0F0F); rd(5'd5, d);
        check(d == 32'hA5A5_0F0F, "R3 comms data", 38'(d), 38'hA5A5_0F0F);
    endtask

    task automatic t_widths;
        logic [31:0] d;
        wr(5'd4, 32'hFFFF_FFFF);  rd(5'd4, d);
        check(d == 32'h3F, "R5 comms control 6 bits", 38'(d), 38'h3F);
        wr(5'd12, 32'hFFFF_FFFF); rd(5'd12, d);
        check(d == 32'h1FF, "R5 wp control value 9 bits", 38'(d), 38'h1FF);
        wr(5'd21, 32'hFFFF_FFFF); rd(5'd21, d);
        check(d == 32'hFF, "R5 wp control mask 8 bits", 38'(d), 38'hFF);
        wr(5'd2, 32'hFFFF_FFFF);  rd(5'd2, d);
        check(d == 32'hFF, "R8 vector catch 8 bits", 38'(d), 38'hFF);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        wr(5'd3, 32'hFFFF_FFFF);  rd(5'd3, d);
        check(d == 32'h0, "R6 address 3", 38'(d), 38'h0);
        wr(5'd25, 32'h5555_AAAA); rd(5'd25, d);
        check(d == 32'h0, "R6 address 25", 38'(d), 38'h0);
    endtask

    task automatic t_status;
        logic [31:0] d;
        core_status = 5'h13;
        wr(5'd1, 32'hFFFF_FFFF); rd(5'd1, d);
        check(d == 32'h13, "R7 status read-only", 38'(d), 38'h13);
    endtask

    task automatic t_monitor;
        logic [31:0] d;
        wr(5'd0, 32'h10);
        check(monitor_mode == 1'b1, "R9 monitor set", 38'(monitor_mode), 38'h1);
        wr(5'd0, 32'h2F);
        check(monitor_mode == 1'b0, "R9 halting selected", 38'(monitor_mode), 38'h0);
        rd(5'd0, d);
        check(d == 32'h2F, "R5 debug control 6 bits", 38'(d), 38'h2F);
    endtask

    task automatic t_pipeline;
        logic [37:0] g;
        scan({1'b0, 5'd8, 32'h0}, g);
        check(g[31:0] == 32'h3F, "R4 first scan returns previous address", 38'(g[31:0]), 38'h3F);
        scan({1'b0, 5'd17, 32'h0}, g);
        check(g[31:0] == 32'hDEAD_BEEF, "R4 second scan returns addr 8", 38'(g[31:0]), 38'hDEAD_BEEF);
        scan({1'b0, 5'd4, 32'h0}, g);
        check(g == {6'h0, 32'h1234_5678}, "R4 R5 third scan returns addr 17", g, {6'h0, 32'h1234_5678});
    endtask

    task automatic t_write_keeps_addr;
        logic [37:0] g;
        scan({1'b0, 5'd12, 32'h0}, g);
        scan({1'b1, 5'd9, 32'h0BAD_F00D}, g);
        scan({1'b0, 5'd4, 32'h0}, g);
        check(g[31:0] == 32'h1FF, "R11 write keeps read address", 38'(g[31:0]), 38'h1FF);
    endtask

    task automatic t_stray_update;
        logic [31:0] d;
        logic [37:0] f;
        f = {1'b1, 5'd8, 32'h1111_2222};
        @(negedge tck);
        for (int i = 0; i < 38; i++) begin
            tdi = f[i]; shift_en = 1'b1; @(negedge tck);
        end
        shift_en = 1'b0; update_en = 1'b1;
        @(negedge tck); update_en = 1'b0;
        rd(5'd8, d);
        check(d == 32'hDEAD_BEEF, "R10 update without capture ignored", 38'(d), 38'hDEAD_BEEF);
    endtask

    task automatic t_reset_again;
        logic [37:0] g;
        logic [31:0] d;
        wr(5'd0, 32'h10);
        scan({1'b0, 5'd8, 32'h0}, g);
        @(negedge tck); trst_n = 1'b0;
        @(negedge tck); trst_n = 1'b1;
        check(monitor_mode == 1'b0, "R1 monitor cleared", 38'(monitor_mode), 38'h0);
        scan({1'b0, 5'd4, 32'h0}, g);
        check(g == 38'h0, "R1 read address back at comms control", g, 38'h0);
        rd(5'd8, d);
        check(d == 32'h0, "R1 watchpoint cleared", 38'(d), 38'h0);
    endtask

    initial begin
        repeat (3) @(negedge tck);
        trst_n = 1'b1;
        t_reset_state();
        t_write_read();
        t_widths();
        t_unmapped();
        t_status();
        t_monitor();
        t_pipeline();
        t_write_keeps_addr();
        t_stray_update();
        t_reset_again();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge tck);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule